// File: doc/BRIEF.md
# Sub-Word Register Access Decoder

This block fronts a 128-byte register window that software reaches with byte, halfword or word accesses in little-endian order. Each accepted access is steered to one of three register targets behind it: a bank of sixteen SCSI core registers, a bank of eight DMA registers, or one 32-bit status-control word. The targets expose only whole-word, index-addressed ports. The decoder therefore converts every access into word operations. A read returns the addressed word, shifted down to the byte offset and trimmed to the access width. A write narrower than a word, or one not on a word boundary, becomes a read-modify-write of the containing word.

The host side is a simple valid/ready request with a registered read response. On the target side there is one index and one read-data input per bank, one write strobe per target, and a shared write-data bus. A full aligned write takes one step. A merged write always takes two steps: first it fetches the current word from the bank, then it writes the merged word back.

Top module: `subword_io_decoder`

## Requirements
- R1: While reset is asserted and right after it, req_ready is 1, rsp_valid is 0 and no write strobe (core_we, dma_we, ctl_we) is active.
- R2: Offsets 0x00 to 0x3F select the core bank with index offset>>2: reads return that word and writes strobe core_we with that index.
- R3: Offsets 0x40 to 0x5F select the DMA bank with index (offset-0x40)>>2: reads return that word and writes strobe dma_we with that index.
- R4: The status-control word is read only at offset exactly 0x70. A write whose word-aligned address is 0x70 strobes ctl_we.
- R5: Every other offset returns zero on read, and a write to it produces no strobe. This includes 0x60 to 0x6F, 0x71 to 0x73 on read, and 0x74 to 0x7F.
- R6: Read data is the selected word shifted right by 8*(offset mod 4) and masked to the low 8*size bits. Bits above the access width are zero.
- R7: A merged write replaces byte lanes offset mod 4 up to offset mod 4 + size - 1 with the low bytes of req_wdata (byte 0 into the lowest lane). All other lanes keep their old value, and lanes past lane 3 are dropped.
- R8: For an access accepted at clock edge E0, a full aligned write strobes its target in the cycle after E0. A merged write strobes in the cycle after that. Each strobe is one cycle wide, req_ready is 0 until the sequence ends, and at most one strobe is active at a time.
- R9: A req_size of 0, 3, 5, 6 or 7 is treated as size 4. Such a write at an aligned offset is a full one-step write.
- R10: A read accepted at edge E0 raises rsp_valid for exactly one cycle, two cycles after E0, carrying the data. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Decoder idle, request accepted this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset within the window |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 32 | Aligned, masked read data |
| core_idx | output | 4 | Core bank word index |
| core_rdata | input | 32 | Core bank word at core_idx |
| core_we | output | 1 | Core bank write strobe |
| dma_idx | output | 3 | DMA bank word index |
| dma_rdata | input | 32 | DMA bank word at dma_idx |
| dma_we | output | 1 | DMA bank write strobe |
| ctl_rdata | input | 32 | Status-control word |
| ctl_we | output | 1 | Status-control write strobe |
| tgt_wdata | output | 32 | Word written to the strobed target |

## Verification
Reads are exercised at every byte offset within a word and at 1, 2 and 4 byte sizes. This separates a correct right shift from an unshifted word, and a correct width mask from a leak of upper bytes. The reads also cover both bank boundaries, the exact and misaligned control offsets, and the gap. Together these show that the raw address chooses the read target while only the aligned address chooses the write target. Writes compare a byte write, a halfword write and an unaligned word write against the neighbouring lanes that must survive, and against the lane that must fall off the word end. The strobe cycle of each write shows whether it took the one-step path or the two-step path. Odd sizes are used to confirm that they collapse onto the full-word path.

// File: rtl/sw_dec_pkg.sv
package sw_dec_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_CORE = 2'd1,
      TGT_DMA  = 2'd2,
      TGT_CTL  = 2'd3
   } tgt_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_EXEC   = 2'd1,
      ST_COMMIT = 2'd2
   } dec_state_e;
endpackage

// File: rtl/sw_addr_map.sv
module sw_addr_map
   import sw_dec_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int LANES      = 4,
   parameter int CORE_WORDS = 16,
   parameter int DMA_BASE   = 64,
   parameter int DMA_WORDS  = 8,
   parameter int CTL_OFF    = 112
) (
   input  logic [ADDR_W-1:0]             addr,
   output tgt_e                          rd_tgt,
   output tgt_e                          fetch_tgt,
   output tgt_e                          wr_tgt,
   output logic [$clog2(CORE_WORDS)-1:0] core_idx,
   output logic [$clog2(DMA_WORDS)-1:0]  dma_idx
);
   localparam int LANE_W  = $clog2(LANES);
   localparam int CORE_IW = $clog2(CORE_WORDS);
   localparam int DMA_IW  = $clog2(DMA_WORDS);
   localparam logic [ADDR_W-1:0] A_CORE_END = ADDR_W'(CORE_WORDS * LANES);
   localparam logic [ADDR_W-1:0] A_DMA_BASE = ADDR_W'(DMA_BASE);
   localparam logic [ADDR_W-1:0] A_DMA_END  = ADDR_W'(DMA_BASE + DMA_WORDS * LANES);
   localparam logic [ADDR_W-1:0] A_CTL      = ADDR_W'(CTL_OFF);
   localparam logic [ADDR_W-1:0] A_CTL_END  = ADDR_W'(CTL_OFF + LANES);

   logic [ADDR_W-1:0] aligned;

   // Control word is an exact match unless wide_ctl covers the fetch span.
   function automatic tgt_e classify(input logic [ADDR_W-1:0] a, input logic wide_ctl);
      if (a < A_CORE_END)                      return TGT_CORE;
      else if (a >= A_DMA_BASE && a < A_DMA_END) return TGT_DMA;
      else if (a == A_CTL)                     return TGT_CTL;
      else if (wide_ctl && a >= A_DMA_END && a < A_CTL_END) return TGT_CTL;
      else                                     return TGT_NONE;
   endfunction

   always_comb begin
      aligned   = (addr >> LANE_W) << LANE_W;
      rd_tgt    = classify(addr, 1'b0);
      fetch_tgt = classify(addr, 1'b1);
      wr_tgt    = classify(aligned, 1'b0);
      core_idx  = CORE_IW'(addr >> LANE_W);
      dma_idx   = DMA_IW'((addr - A_DMA_BASE) >> LANE_W);
   end
endmodule

// File: rtl/sw_read_align.sv
module sw_read_align #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]              word,
   input  logic [$clog2(DATA_W/8)-1:0]    off,
   input  logic [$clog2(DATA_W/8):0]      size,
   output logic [DATA_W-1:0]              rdata
);
   localparam int LANES  = DATA_W / 8;
   localparam int SIZE_W = $clog2(LANES) + 1;

   logic [DATA_W-1:0] mask;

   for (genvar l = 0; l < LANES; l++) begin : g_mask
      assign mask[8*l +: 8] = (SIZE_W'(l) < size) ? 8'hFF : 8'h00;
   end

   assign rdata = (word >> {off, 3'b000}) & mask;
endmodule

// File: rtl/sw_lane_merge.sv
module sw_lane_merge #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]              cur,
   input  logic [DATA_W-1:0]              wdata,
   input  logic [$clog2(DATA_W/8)-1:0]    off,
   input  logic [$clog2(DATA_W/8):0]      size,
   output logic [DATA_W-1:0]              merged
);
   localparam int LANES  = DATA_W / 8;
   localparam int LANE_W = $clog2(LANES);
   localparam int SIZE_W = LANE_W + 1;

   logic [DATA_W-1:0] wsh;
   logic [SIZE_W-1:0] first;
   logic [SIZE_W-1:0] last_ex;

   assign wsh     = wdata << {off, 3'b000};
   assign first   = {1'b0, off};
   assign last_ex = first + size;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic hit;
      assign hit = (SIZE_W'(l) >= first) && (SIZE_W'(l) < last_ex);
      assign merged[8*l +: 8] = hit ? wsh[8*l +: 8] : cur[8*l +: 8];
   end
endmodule

// File: rtl/subword_io_decoder.sv
module subword_io_decoder
   import sw_dec_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 32,
   parameter int CORE_WORDS = 16,
   parameter int DMA_BASE   = 64,
   parameter int DMA_WORDS  = 8,
   parameter int CTL_OFF    = 112
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic                          req_write,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [$clog2(DATA_W/8):0]     req_size,
   input  logic [DATA_W-1:0]             req_wdata,
   output logic                          rsp_valid,
   output logic [DATA_W-1:0]             rsp_rdata,
   output logic [$clog2(CORE_WORDS)-1:0] core_idx,
   input  logic [DATA_W-1:0]             core_rdata,
   output logic                          core_we,
   output logic [$clog2(DMA_WORDS)-1:0]  dma_idx,
   input  logic [DATA_W-1:0]             dma_rdata,
   output logic                          dma_we,
   input  logic [DATA_W-1:0]             ctl_rdata,
   output logic                          ctl_we,
   output logic [DATA_W-1:0]             tgt_wdata
);
   localparam int LANES  = DATA_W / 8;
   localparam int LANE_W = $clog2(LANES);
   localparam int SIZE_W = LANE_W + 1;
   localparam logic [SIZE_W-1:0] FULL = SIZE_W'(LANES);

   // Elaboration-time parameter checks
   if (DATA_W % 8 != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power-of-two number of bytes, at least 2");
   end
   if (CORE_WORDS < 2 || DMA_WORDS < 2) begin : g_bad_banks
      $error("each bank needs at least two words");
   end
   if (CORE_WORDS * LANES > DMA_BASE || DMA_BASE % LANES != 0) begin : g_bad_dma_base
      $error("DMA bank must start word aligned above the core bank");
   end
   if (DMA_BASE + DMA_WORDS * LANES > CTL_OFF || CTL_OFF % LANES != 0) begin : g_bad_ctl
      $error("control word must be word aligned above the DMA bank");
   end
   if (CTL_OFF + LANES >= (1 << ADDR_W)) begin : g_bad_window
      $error("control word must leave room below the window top");
   end

   dec_state_e          state;
   logic                r_write;
   logic [ADDR_W-1:0]   r_addr;
   logic [SIZE_W-1:0]   r_size;
   logic [DATA_W-1:0]   r_wdata;
   logic [DATA_W-1:0]   merged_q;
   logic [SIZE_W-1:0]   size_in;
   logic [LANE_W-1:0]   off;
   logic                narrow;
   tgt_e                rd_tgt, fetch_tgt, wr_tgt, src_tgt;
   logic [DATA_W-1:0]   cur_word, rd_aligned, merged;
   logic                wr_step;

   // Unsupported sizes collapse onto a full-word access
   always_comb begin
      size_in = FULL;
      if (req_size != '0 && req_size <= FULL && (req_size & (req_size - 1'b1)) == '0)
         size_in = req_size;
   end

   assign off    = r_addr[LANE_W-1:0];
   assign narrow = (r_size != FULL) || (off != '0);

   sw_addr_map #(
      .ADDR_W(ADDR_W), .LANES(LANES), .CORE_WORDS(CORE_WORDS),
      .DMA_BASE(DMA_BASE), .DMA_WORDS(DMA_WORDS), .CTL_OFF(CTL_OFF)
   ) u_map (
      .addr(r_addr), .rd_tgt(rd_tgt), .fetch_tgt(fetch_tgt), .wr_tgt(wr_tgt),
      .core_idx(core_idx), .dma_idx(dma_idx)
   );

   assign src_tgt = r_write ? fetch_tgt : rd_tgt;

   always_comb begin
      unique case (src_tgt)
         TGT_CORE: cur_word = core_rdata;
         TGT_DMA:  cur_word = dma_rdata;
         TGT_CTL:  cur_word = ctl_rdata;
         default:  cur_word = '0;
      endcase
   end

   sw_read_align #(.DATA_W(DATA_W)) u_align (
      .word(cur_word), .off(off), .size(r_size), .rdata(rd_aligned)
   );

   sw_lane_merge #(.DATA_W(DATA_W)) u_merge (
      .cur(cur_word), .wdata(r_wdata), .off(off), .size(r_size), .merged(merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         r_write   <= 1'b0;
         r_addr    <= '0;
         r_size    <= FULL;
         r_wdata   <= '0;
         merged_q  <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state)
            ST_IDLE: if (req_valid) begin
               r_write <= req_write;
               r_addr  <= req_addr;
               r_size  <= size_in;
               r_wdata <= req_wdata;
               state   <= ST_EXEC;
            end
            ST_EXEC: begin
               if (!r_write) begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= rd_aligned;
                  state     <= ST_IDLE;
               end else if (narrow) begin
                  merged_q <= merged;
                  state    <= ST_COMMIT;
               end else begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign wr_step   = (state == ST_COMMIT) || (state == ST_EXEC && r_write && !narrow);
   assign core_we   = wr_step && (wr_tgt == TGT_CORE);
   assign dma_we    = wr_step && (wr_tgt == TGT_DMA);
   assign ctl_we    = wr_step && (wr_tgt == TGT_CTL);
   assign tgt_wdata = (state == ST_COMMIT) ? merged_q : r_wdata;
endmodule

// File: rtl/sw_dec_checker.sv
module sw_dec_checker (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic req_write,
   input logic rsp_valid,
   input logic core_we,
   input logic dma_we,
   input logic ctl_we
);
   logic any_we;
   assign any_we = core_we | dma_we | ctl_we;

   p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({core_we, dma_we, ctl_we}));

   p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      any_we |=> !any_we);

   p_no_strobe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !any_we);

   p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_read_response_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_write) |=> ##1 rsp_valid);

   p_write_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write) |=> ##1 !rsp_valid);

   p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

bind subword_io_decoder sw_dec_checker u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_write(req_write), .rsp_valid(rsp_valid),
   .core_we(core_we), .dma_we(dma_we), .ctl_we(ctl_we)
);

// File: tb/subword_io_decoder_tb.sv
module subword_io_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [6:0]  req_addr = '0;
   logic [2:0]  req_size = 3'd4;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [3:0]  core_idx;
   logic [31:0] core_rdata;
   logic        core_we;
   logic [2:0]  dma_idx;
   logic [31:0] dma_rdata;
   logic        dma_we;
   logic [31:0] ctl_rdata;
   logic        ctl_we;
   logic [31:0] tgt_wdata;

   logic [31:0] core_mem [16];
   logic [31:0] dma_mem  [8];
   logic [31:0] ctl_reg;
   logic        preload = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int o_we_cnt, o_we_cyc, o_we_tgt, o_rsp_cnt, o_rsp_cyc, o_rdy_cyc;
   logic [31:0] o_rsp_data;
   logic        o_acc_ready;

   always #5 clk = ~clk;

   subword_io_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .core_idx(core_idx), .core_rdata(core_rdata), .core_we(core_we),
      .dma_idx(dma_idx), .dma_rdata(dma_rdata), .dma_we(dma_we),
      .ctl_rdata(ctl_rdata), .ctl_we(ctl_we), .tgt_wdata(tgt_wdata)
   );

   // Target register model: byte b of core word i = {i,b}; DMA word j byte b = 0x80+16j+b
   assign core_rdata = core_mem[core_idx];
   assign dma_rdata  = dma_mem[dma_idx];
   assign ctl_rdata  = ctl_reg;

   always @(posedge clk) begin
      if (preload) begin
         for (int i = 0; i < 16; i++)
            core_mem[i] <= {8'(i*16+3), 8'(i*16+2), 8'(i*16+1), 8'(i*16)};
         for (int j = 0; j < 8; j++)
            dma_mem[j] <= {8'(128+j*16+3), 8'(128+j*16+2), 8'(128+j*16+1), 8'(128+j*16)};
         ctl_reg <= 32'h7A6B5C4D;
      end else begin
         if (core_we) core_mem[core_idx] <= tgt_wdata;
         if (dma_we)  dma_mem[dma_idx]   <= tgt_wdata;
         if (ctl_we)  ctl_reg            <= tgt_wdata;
      end
   end

   // {addr, size, expected read data}
   localparam logic [41:0] VEC [16] = '{
      {7'h08, 3'd4, 32'h23222120},   // R2 core word 2
      {7'h09, 3'd1, 32'h00000021},   // R6 byte at lane 1
      {7'h0A, 3'd2, 32'h00002322},   // R6 halfword at lane 2
      {7'h3F, 3'd1, 32'h000000F3},   // R2 last core byte
      {7'h0B, 3'd2, 32'h00000023},   // R6 halfword past word end
      {7'h40, 3'd4, 32'h83828180},   // R3 first DMA word
      {7'h54, 3'd4, 32'hD3D2D1D0},   // R3 DMA word 5
      {7'h5D, 3'd1, 32'h000000F1},   // R3 last DMA word, lane 1
      {7'h70, 3'd4, 32'h7A6B5C4D},   // R4 control word
      {7'h72, 3'd2, 32'h00000000},   // R5 control read off exact offset
      {7'h60, 3'd4, 32'h00000000},   // R5 gap
      {7'h7C, 3'd4, 32'h00000000},   // R5 above control
      {7'h0C, 3'd3, 32'h33323130},   // R9 size 3
      {7'h0C, 3'd0, 32'h33323130},   // R9 size 0
      {7'h12, 3'd7, 32'h00004342},   // R9 size 7 at lane 2
      {7'h71, 3'd1, 32'h00000000}    // R5 control byte 1 reads zero
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_acc(input logic wr, input logic [6:0] a, input logic [2:0] sz,
                         input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
      o_acc_ready = req_ready;
      @(posedge clk);
      o_we_cnt = 0; o_we_cyc = 0; o_we_tgt = 0;
      o_rsp_cnt = 0; o_rsp_cyc = 0; o_rsp_data = '0; o_rdy_cyc = 0;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         if (k == 1) req_valid = 1'b0;
         if (core_we | dma_we | ctl_we) begin
            o_we_cnt++;
            o_we_cyc = k;
            o_we_tgt = core_we ? 1 : (dma_we ? 2 : 3);
         end
         if (rsp_valid) begin
            o_rsp_cnt++;
            o_rsp_cyc = k;
            o_rsp_data = rsp_rdata;
         end
         if (req_ready && o_rdy_cyc == 0) o_rdy_cyc = k;
      end
   endtask

   task automatic chk_write(input string tag, input int tgt, input int cyc);
      chk({tag, " strobe target"}, 32'(o_we_tgt), 32'(tgt));
      chk({tag, " strobe count"},  32'(o_we_cnt), (tgt == 0) ? 32'd0 : 32'd1);
      if (tgt != 0) begin
         chk({tag, " R8 strobe cycle"}, 32'(o_we_cyc), 32'(cyc));
         chk({tag, " R8 ready return"}, 32'(o_rdy_cyc), 32'(cyc + 1));
      end
      chk({tag, " R10 no response"}, 32'(o_rsp_cnt), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk("R1 ready in reset", 32'(req_ready), 32'd1);
      chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      chk("R1 strobes in reset", {29'd0, core_we, dma_we, ctl_we}, 32'd0);
      rst_n = 1'b1;
      preload = 1'b1;
      @(negedge clk);
      preload = 1'b0;
      chk("R1 ready after reset", 32'(req_ready), 32'd1);
      chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);

      // Read vector table
      for (int v = 0; v < 16; v++) begin
         do_acc(1'b0, VEC[v][41:35], VEC[v][34:32], 32'hFFFF_FFFF);
         chk($sformatf("R6 read vec %0d data", v), o_rsp_data, VEC[v][31:0]);
         chk($sformatf("R10 read vec %0d cycle", v), 32'(o_rsp_cyc), 32'd2);
         chk($sformatf("R10 read vec %0d count", v), 32'(o_rsp_cnt), 32'd1);
         chk($sformatf("R5 read vec %0d no strobe", v), 32'(o_we_cnt), 32'd0);
      end

      // R2 full aligned core write, one step
      do_acc(1'b1, 7'h04, 3'd4, 32'hDEADBEEF);
      chk("R2 accepted", 32'(o_acc_ready), 32'd1);
      chk_write("R2 full write", 1, 1);
      chk("R2 core word 1", core_mem[1], 32'hDEADBEEF);
      chk("R2 core word 0 untouched", core_mem[0], 32'h03020100);

      // R7 byte write at lane 1, two steps
      do_acc(1'b1, 7'h05, 3'd1, 32'h000000AA);
      chk_write("R7 byte write", 1, 2);
      chk("R7 byte merge", core_mem[1], 32'hDEADAAEF);

      // R7 halfword write into DMA word 1 (R3 index)
      do_acc(1'b1, 7'h46, 3'd2, 32'h00001234);
      chk_write("R3 halfword write", 2, 2);
      chk("R7 halfword merge", dma_mem[1], 32'h12349190);

      // R7 unaligned word write: only lane 3 lands, rest dropped
      do_acc(1'b1, 7'h4B, 3'd4, 32'h55667788);
      chk_write("R7 unaligned word", 2, 2);
      chk("R7 lanes past end dropped", dma_mem[2], 32'h88A2A1A0);
      chk("R3 DMA word 3 untouched", dma_mem[3], 32'hB3B2B1B0);

      // R4 control writes
      do_acc(1'b1, 7'h70, 3'd4, 32'hCAFEF00D);
      chk_write("R4 control full write", 3, 1);
      chk("R4 control value", ctl_reg, 32'hCAFEF00D);
      do_acc(1'b1, 7'h73, 3'd1, 32'h00000011);
      chk_write("R4 control byte write", 3, 2);
      chk("R4 control merge", ctl_reg, 32'h11FEF00D);

      // R5 writes to unmapped offsets do nothing
      do_acc(1'b1, 7'h60, 3'd4, 32'h0BADF00D);
      chk_write("R5 gap write", 0, 0);
      do_acc(1'b1, 7'h74, 3'd4, 32'h0BADF00D);
      chk_write("R5 above control write", 0, 0);
      do_acc(1'b1, 7'h62, 3'd1, 32'h000000EE);
      chk_write("R5 gap byte write", 0, 0);
      do_acc(1'b0, 7'h70, 3'd4, 32'h0);
      chk("R5 control unchanged", o_rsp_data, 32'h11FEF00D);
      chk("R5 DMA word 7 unchanged", dma_mem[7], 32'hF3F2F1F0);

      // R9 size 3 write is a full one-step write
      do_acc(1'b1, 7'h10, 3'd3, 32'h01020304);
      chk_write("R9 size 3 write", 1, 1);
      chk("R9 full word stored", core_mem[4], 32'h01020304);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule